// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one programmable logic cell of the kind found at the output of a sum-of-products array. It takes a single sum input and six control terms. Its storage bit can load the sum (data mode) or flip when the sum is high (toggle mode). A combinational bypass setting sends the sum past the flip-flop. The bit is clocked by one of four clocks, and each cell picks the active edge of its own clock. Clocks 1 to 3 can each come from an external line or from an internally generated logic signal. Clock 0 is always external.

Two control terms can act as an asynchronous preset or clear, and this function can be switched off. The other four control terms can each serve as the output enable. The output can also be held always on or always off. A global active-low tri-state input, when enabled, turns the output off whatever the local enable is.

The cell has two feedback outputs. The first carries the cell's internal value. The second carries what is on the pad: the driven value when the output is enabled, and the external input when it is not. The configuration inputs are static settings, held constant while the cell runs.

Top module: `cfg_macrocell`

## Requirements
- R1: With `cfg_toggle_i`=0 and `cfg_bypass_i`=0, each active edge of the selected clock loads `sum_i` into the stored bit, which appears on `mc_fb_o`.
- R2: With `cfg_toggle_i`=1, each active edge inverts the stored bit when `sum_i`=1 and leaves it unchanged when `sum_i`=0.
- R3: `cfg_clk_sel_i` (0 to 3) picks the clock. For indices 1 to 3, `cfg_clk_int_i`=1 takes `int_clk_i[index-1]` in place of `ext_clk_i[index]`. For index 0, `ext_clk_i[0]` is always used. Edges on any clock source that is not selected leave the stored bit unchanged.
- R4: `cfg_clk_fall_i`=0 makes the rising edge of the selected source active. `cfg_clk_fall_i`=1 makes the falling edge active, and the rising edge then has no effect.
- R5: When `cfg_init_en_i`=1, the term `ct_i[0]` (if `cfg_init_ct1_i`=0) or `ct_i[1]` (if `cfg_init_ct1_i`=1) acts at once, without a clock. It sets the bit to 1 if `cfg_init_preset_i`=1 and clears it to 0 otherwise, and it overrides clock edges while asserted. The term that is not selected has no effect, and neither term has any effect when `cfg_init_en_i`=0.
- R6: While `rst_n_i` is low, the stored bit is 0, even if a preset term is asserted.
- R7: `pad_oe_o` follows `cfg_oe_sel_i`: codes 0 to 3 follow `ct_i[2]` to `ct_i[5]` in that order, code 4 is always enabled, and codes 5 to 7 are always disabled.
- R8: When `cfg_gts_en_i`=1 and `gts_n_i`=0, `pad_oe_o` is 0 regardless of the local enable. When `cfg_gts_en_i`=0, `gts_n_i` has no effect.
- R9: `pad_o` and `mc_fb_o` carry the cell value. `pad_fb_o` equals `pad_o` when `pad_oe_o`=1 and equals `pad_in_i` when `pad_oe_o`=0. `mc_fb_o` keeps carrying the cell value when the output is disabled.
- R10: With `cfg_bypass_i`=1, the cell value is `sum_i` combinationally. The stored bit is not disturbed and reappears when bypass is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Power-on reset, active low, asynchronous clear |
| ext_clk_i | input | 4 | External clock lines 0 to 3 |
| int_clk_i | input | 3 | Internally generated clocks for indices 1 to 3 |
| sum_i | input | 1 | Sum-of-products input |
| ct_i | input | 6 | Control terms: [1:0] initialisation, [5:2] enables |
| gts_n_i | input | 1 | Global tri-state, active low |
| pad_in_i | input | 1 | Value seen on the pad from outside |
| cfg_toggle_i | input | 1 | 1 = toggle storage, 0 = data storage |
| cfg_bypass_i | input | 1 | 1 = combinational path |
| cfg_clk_sel_i | input | 2 | Clock index |
| cfg_clk_int_i | input | 1 | Use the internal source for clock indices 1 to 3 |
| cfg_clk_fall_i | input | 1 | 1 = falling edge active |
| cfg_init_en_i | input | 1 | Enable asynchronous initialisation |
| cfg_init_ct1_i | input | 1 | 1 = use ct_i[1], 0 = use ct_i[0] |
| cfg_init_preset_i | input | 1 | 1 = preset, 0 = clear |
| cfg_oe_sel_i | input | 3 | Output enable source code |
| cfg_gts_en_i | input | 1 | Let gts_n_i act on this cell |
| mc_fb_o | output | 1 | Cell value feedback |
| pad_o | output | 1 | Value driven toward the pad |
| pad_oe_o | output | 1 | Pad driver enable |
| pad_fb_o | output | 1 | Pad-side feedback |

## Verification
Some properties are checked at every sampled edge of clock 0: the global override and the fixed enable codes, the choice the pad feedback makes between driven and external values, the bypass path, the clear held during reset, and the bit reading high once a preset term rises. Other behaviours appear only in the bench's scenarios, because they depend on an ordered series of edges and a running expected value. These are data loading and toggling on each clock and polarity choice, the rejection of edges from clock sources that are not selected, term selection and the disable for initialisation, and the bit surviving a bypass episode.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int CLK_N     = 4;
  localparam int CLK_SEL_W = $clog2(CLK_N);
  localparam int CT_N      = 6;
  localparam int INIT_CT_N = 2;
  localparam int OE_CT_N   = CT_N - INIT_CT_N;
  localparam int OE_SEL_W  = 3;
  localparam logic [OE_SEL_W-1:0] OE_ALWAYS_ON = OE_SEL_W'(OE_CT_N);

  // Next stored value for data or toggle storage.
  function automatic logic reg_next(input logic toggle_mode, input logic cur, input logic din);
    return toggle_mode ? (cur ^ din) : din;
  endfunction

  // Local enable from the selector code and the enable terms.
  function automatic logic oe_pick(input logic [OE_SEL_W-1:0] sel,
                                   input logic [OE_CT_N-1:0] terms);
    logic r;
    r = (sel == OE_ALWAYS_ON);
    for (int i = 0; i < OE_CT_N; i++) begin
      if (sel == OE_SEL_W'(i)) r = terms[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int N = mc_pkg::CLK_N
) (
  input  logic [N-1:0]         ext_clk_i,
  input  logic [N-2:0]         int_clk_i,
  input  logic [$clog2(N)-1:0] sel_i,
  input  logic                 use_int_i,
  input  logic                 falling_i,
  output logic                 clk_o
);
  logic [N-1:0] src;

  assign src[0] = ext_clk_i[0];
  for (genvar g = 1; g < N; g++) begin : g_src
    assign src[g] = use_int_i ? int_clk_i[g-1] : ext_clk_i[g];
  end

  assign clk_o = src[sel_i] ^ falling_i;
endmodule

// File: rtl/mc_init_ctl.sv
module mc_init_ctl #(
  parameter int N = mc_pkg::INIT_CT_N
) (
  input  logic         por_n_i,
  input  logic [N-1:0] ct_i,
  input  logic         en_i,
  input  logic         use_ct1_i,
  input  logic         preset_i,
  output logic         set_o,
  output logic         clr_o
);
  logic hit;

  assign hit   = en_i & (use_ct1_i ? ct_i[1] : ct_i[0]);
  assign clr_o = ~por_n_i | (hit & ~preset_i);
  assign set_o = hit & preset_i & por_n_i;
endmodule

// File: rtl/mc_storage.sv
module mc_storage (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic toggle_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= mc_pkg::reg_next(toggle_i, q_o, d_i);
  end
endmodule

// File: rtl/mc_out_ctl.sv
module mc_out_ctl #(
  parameter int N  = mc_pkg::OE_CT_N,
  parameter int SW = mc_pkg::OE_SEL_W
) (
  input  logic          value_i,
  input  logic [SW-1:0] oe_sel_i,
  input  logic [N-1:0]  terms_i,
  input  logic          gts_en_i,
  input  logic          gts_n_i,
  input  logic          pad_in_i,
  output logic          pad_o,
  output logic          pad_oe_o,
  output logic          pad_fb_o
);
  logic local_oe;
  logic global_off;

  assign local_oe   = mc_pkg::oe_pick(oe_sel_i, terms_i);
  assign global_off = gts_en_i & ~gts_n_i;
  assign pad_oe_o   = local_oe & ~global_off;
  assign pad_o      = value_i;
  assign pad_fb_o   = pad_oe_o ? value_i : pad_in_i;
endmodule

// File: rtl/cfg_macrocell.sv
module cfg_macrocell (
  input  logic                            rst_n_i,
  input  logic [mc_pkg::CLK_N-1:0]        ext_clk_i,
  input  logic [mc_pkg::CLK_N-2:0]        int_clk_i,
  input  logic                            sum_i,
  input  logic [mc_pkg::CT_N-1:0]         ct_i,
  input  logic                            gts_n_i,
  input  logic                            pad_in_i,
  input  logic                            cfg_toggle_i,
  input  logic                            cfg_bypass_i,
  input  logic [mc_pkg::CLK_SEL_W-1:0]    cfg_clk_sel_i,
  input  logic                            cfg_clk_int_i,
  input  logic                            cfg_clk_fall_i,
  input  logic                            cfg_init_en_i,
  input  logic                            cfg_init_ct1_i,
  input  logic                            cfg_init_preset_i,
  input  logic [mc_pkg::OE_SEL_W-1:0]     cfg_oe_sel_i,
  input  logic                            cfg_gts_en_i,
  output logic                            mc_fb_o,
  output logic                            pad_o,
  output logic                            pad_oe_o,
  output logic                            pad_fb_o
);
  import mc_pkg::*;

  // Named internal events, visible to the bound checker.
  logic mc_clk_w;
  logic init_set_w;
  logic init_clr_w;
  logic reg_q_w;
  logic cell_w;

  mc_clk_sel #(.N(CLK_N)) u_clk (
    .ext_clk_i (ext_clk_i),
    .int_clk_i (int_clk_i),
    .sel_i     (cfg_clk_sel_i),
    .use_int_i (cfg_clk_int_i),
    .falling_i (cfg_clk_fall_i),
    .clk_o     (mc_clk_w)
  );

  mc_init_ctl #(.N(INIT_CT_N)) u_init (
    .por_n_i   (rst_n_i),
    .ct_i      (ct_i[INIT_CT_N-1:0]),
    .en_i      (cfg_init_en_i),
    .use_ct1_i (cfg_init_ct1_i),
    .preset_i  (cfg_init_preset_i),
    .set_o     (init_set_w),
    .clr_o     (init_clr_w)
  );

  mc_storage u_reg (
    .clk_i    (mc_clk_w),
    .set_i    (init_set_w),
    .clr_i    (init_clr_w),
    .toggle_i (cfg_toggle_i),
    .d_i      (sum_i),
    .q_o      (reg_q_w)
  );

  assign cell_w  = cfg_bypass_i ? sum_i : reg_q_w;
  assign mc_fb_o = cell_w;

  mc_out_ctl #(.N(OE_CT_N), .SW(OE_SEL_W)) u_out (
    .value_i  (cell_w),
    .oe_sel_i (cfg_oe_sel_i),
    .terms_i  (ct_i[CT_N-1:INIT_CT_N]),
    .gts_en_i (cfg_gts_en_i),
    .gts_n_i  (gts_n_i),
    .pad_in_i (pad_in_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o),
    .pad_fb_o (pad_fb_o)
  );
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk (
  input logic       clk0_i,
  input logic       rst_n_i,
  input logic       gts_en_i,
  input logic       gts_n_i,
  input logic [2:0] oe_sel_i,
  input logic       pad_oe_i,
  input logic       pad_o_i,
  input logic       pad_in_i,
  input logic       pad_fb_i,
  input logic       bypass_i,
  input logic       sum_i,
  input logic       mc_fb_i,
  input logic       reg_q_i,
  input logic       init_set_i
);
  // R8: global override wins over any local enable
  a_r8_gts_forces_off: assert property (@(posedge clk0_i) disable iff (!rst_n_i)
    (gts_en_i && !gts_n_i) |-> !pad_oe_i);

  // R7: codes above the always-on code disable the driver
  a_r7_off_codes: assert property (@(posedge clk0_i) disable iff (!rst_n_i)
    (oe_sel_i > 3'd4) |-> !pad_oe_i);

  // R7: always-on code enables unless globally overridden
  a_r7_on_code: assert property (@(posedge clk0_i) disable iff (!rst_n_i)
    (oe_sel_i == 3'd4 && !(gts_en_i && !gts_n_i)) |-> pad_oe_i);

  // R9: pad feedback follows the outside value when not driving
  a_r9_pad_fb_input: assert property (@(posedge clk0_i) disable iff (!rst_n_i)
    !pad_oe_i |-> (pad_fb_i == pad_in_i));

  // R9: pad feedback follows the driven value when driving
  a_r9_pad_fb_driven: assert property (@(posedge clk0_i) disable iff (!rst_n_i)
    pad_oe_i |-> (pad_fb_i == pad_o_i));

  // R10: bypass routes the sum to the cell feedback
  a_r10_bypass: assert property (@(posedge clk0_i) disable iff (!rst_n_i)
    bypass_i |-> (mc_fb_i == sum_i));

  // R6: stored bit is zero while reset is held
  a_r6_por_clear: assert property (@(posedge clk0_i)
    !rst_n_i |-> (reg_q_i == 1'b0));

  // R5: a rising preset term leaves the bit set
  a_r5_preset_sets: assert property (@(posedge clk0_i) disable iff (!rst_n_i)
    ($rose(init_set_i) && $past(rst_n_i)) |-> reg_q_i);
endmodule

bind cfg_macrocell mc_macrocell_chk u_chk (
  .clk0_i     (ext_clk_i[0]),
  .rst_n_i    (rst_n_i),
  .gts_en_i   (cfg_gts_en_i),
  .gts_n_i    (gts_n_i),
  .oe_sel_i   (cfg_oe_sel_i),
  .pad_oe_i   (pad_oe_o),
  .pad_o_i    (pad_o),
  .pad_in_i   (pad_in_i),
  .pad_fb_i   (pad_fb_o),
  .bypass_i   (cfg_bypass_i),
  .sum_i      (sum_i),
  .mc_fb_i    (mc_fb_o),
  .reg_q_i    (reg_q_w),
  .init_set_i (init_set_w)
);

// File: tb/tb_cfg_macrocell.sv
module tb_cfg_macrocell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:1] ext_hi;
  logic [2:0] int_clk;
  logic       sum;
  logic [5:0] ct;
  logic       gts_n, pad_in;
  logic       cfg_toggle, cfg_bypass, cfg_clk_int, cfg_clk_fall;
  logic [1:0] cfg_clk_sel;
  logic       cfg_init_en, cfg_init_ct1, cfg_init_preset, cfg_gts_en;
  logic [2:0] cfg_oe_sel;
  logic       mc_fb, pad_o, pad_oe, pad_fb;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cfg_macrocell dut (
    .rst_n_i(rst_n), .ext_clk_i({ext_hi, clk}), .int_clk_i(int_clk), .sum_i(sum),
    .ct_i(ct), .gts_n_i(gts_n), .pad_in_i(pad_in), .cfg_toggle_i(cfg_toggle),
    .cfg_bypass_i(cfg_bypass), .cfg_clk_sel_i(cfg_clk_sel), .cfg_clk_int_i(cfg_clk_int),
    .cfg_clk_fall_i(cfg_clk_fall), .cfg_init_en_i(cfg_init_en), .cfg_init_ct1_i(cfg_init_ct1),
    .cfg_init_preset_i(cfg_init_preset), .cfg_oe_sel_i(cfg_oe_sel), .cfg_gts_en_i(cfg_gts_en),
    .mc_fb_o(mc_fb), .pad_o(pad_o), .pad_oe_o(pad_oe), .pad_fb_o(pad_fb)
  );

  // {oe_sel[2:0], CT5..CT2[3:0], gts_en, gts_n, expected enable}
  localparam logic [9:0] OE_VEC [13] = '{
    {3'd0, 4'b0001, 1'b0, 1'b1, 1'b1},
    {3'd0, 4'b1110, 1'b0, 1'b1, 1'b0},
    {3'd1, 4'b0010, 1'b0, 1'b1, 1'b1},
    {3'd1, 4'b1101, 1'b0, 1'b1, 1'b0},
    {3'd2, 4'b0100, 1'b0, 1'b1, 1'b1},
    {3'd3, 4'b1000, 1'b0, 1'b1, 1'b1},
    {3'd3, 4'b0111, 1'b0, 1'b1, 1'b0},
    {3'd4, 4'b0000, 1'b0, 1'b1, 1'b1},
    {3'd5, 4'b1111, 1'b0, 1'b1, 1'b0},
    {3'd7, 4'b1111, 1'b0, 1'b1, 1'b0},
    {3'd4, 4'b0000, 1'b1, 1'b0, 1'b0},
    {3'd4, 4'b0000, 1'b0, 1'b0, 1'b1},
    {3'd0, 4'b0001, 1'b1, 1'b1, 1'b1}
  };
  localparam logic [4:0] SEQ = 5'b01011; // applied bit 0 first: 1,1,0,1,0

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse_line(input bit use_int, input int idx);
    if (use_int) int_clk[idx-1] = 1'b1; else ext_hi[idx] = 1'b1;
    #3;
    if (use_int) int_clk[idx-1] = 1'b0; else ext_hi[idx] = 1'b0;
    #3;
  endtask

  task automatic do_edge(input int s, input bit use_int, input bit fall);
    if (s == 0) begin
      if (fall) @(negedge clk); else @(posedge clk);
      #2;
    end else begin
      pulse_line(use_int, s);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); #3;
    rst_n = 1'b0; #2;
    rst_n = 1'b1; #2;
  endtask

  initial begin
    int_clk = '0;
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic refq;
    rst_n = 1'b0; ext_hi = '0; sum = 1'b0; ct = '0; gts_n = 1'b1; pad_in = 1'b1;
    cfg_toggle = 1'b0; cfg_bypass = 1'b0; cfg_clk_sel = 2'd0; cfg_clk_int = 1'b0;
    cfg_clk_fall = 1'b0; cfg_init_en = 1'b0; cfg_init_ct1 = 1'b0; cfg_init_preset = 1'b0;
    cfg_oe_sel = 3'd0; cfg_gts_en = 1'b0;
    #15;
    chk(mc_fb, 1'b0, "R6 reset state bit");
    chk(pad_oe, 1'b0, "R7 reset state enable");
    rst_n = 1'b1;
    #5;

    // R7 R8 R9: enable and override table
    for (int v = 0; v < 13; v++) begin
      cfg_oe_sel = OE_VEC[v][9:7];
      ct = {OE_VEC[v][6:3], 2'b00};
      cfg_gts_en = OE_VEC[v][2];
      gts_n = OE_VEC[v][1];
      #2;
      chk(pad_oe, OE_VEC[v][0], $sformatf("R7/R8 vector %0d enable", v));
      chk(pad_fb, OE_VEC[v][0] ? 1'b0 : 1'b1, $sformatf("R9 vector %0d pad feedback", v));
      chk(pad_o, 1'b0, $sformatf("R9 vector %0d pad value", v));
    end
    ct = '0; cfg_gts_en = 1'b0; gts_n = 1'b1; cfg_oe_sel = 3'd4;

    // R1 R2 R3 R4 on every clock, source and polarity
    for (int s = 0; s < 4; s++) begin
      for (int src = 0; src < 2; src++) begin
        if (s == 0 && src == 1) continue;
        for (int f = 0; f < 2; f++) begin
          for (int m = 0; m < 2; m++) begin
            cfg_clk_sel = 2'(s); cfg_clk_int = src[0];
            cfg_clk_fall = f[0]; cfg_toggle = m[0];
            pulse_reset();
            refq = 1'b0;
            for (int k = 0; k < 5; k++) begin
              sum = SEQ[k];
              do_edge(s, src[0], f[0]);
              refq = m[0] ? (refq ^ SEQ[k]) : SEQ[k];
              chk(mc_fb, refq, $sformatf("%s clk%0d int%0d fall%0d step%0d",
                  m[0] ? "R2" : "R1", s, src, f, k));
            end
            sum = m[0] ? 1'b1 : ~refq;
            if (s == 0) begin
              pulse_line(1'b0, 1);
              pulse_line(1'b1, 1);
            end else begin
              pulse_line(~src[0], s);
              pulse_line(1'b0, (s == 3) ? 1 : s + 1);
            end
            chk(mc_fb, refq, $sformatf("R3 unselected source clk%0d int%0d", s, src));
          end
        end
      end
    end

    // R4: explicit edge direction on clock 2
    cfg_clk_sel = 2'd2; cfg_clk_int = 1'b0; cfg_clk_fall = 1'b1; cfg_toggle = 1'b0;
    pulse_reset();
    sum = 1'b1;
    ext_hi[2] = 1'b1; #3;
    chk(mc_fb, 1'b0, "R4 rising ignored in falling mode");
    ext_hi[2] = 1'b0; #3;
    chk(mc_fb, 1'b1, "R4 falling edge loads");
    cfg_clk_fall = 1'b0;
    pulse_reset();
    ext_hi[2] = 1'b1; #3;
    chk(mc_fb, 1'b1, "R4 rising edge loads");
    ext_hi[2] = 1'b0; #3;

    // R5: asynchronous initialisation
    cfg_clk_sel = 2'd1; cfg_clk_int = 1'b0; cfg_clk_fall = 1'b0; cfg_toggle = 1'b0;
    pulse_reset();
    cfg_init_en = 1'b1; cfg_init_ct1 = 1'b0; cfg_init_preset = 1'b1;
    ct[0] = 1'b1; #2;
    chk(mc_fb, 1'b1, "R5 preset from term 0");
    ct[0] = 1'b0; #2;
    chk(mc_fb, 1'b1, "R5 bit held after preset release");
    cfg_init_preset = 1'b0;
    ct[0] = 1'b1; #2;
    chk(mc_fb, 1'b0, "R5 clear from term 0");
    ct[0] = 1'b0;
    cfg_init_ct1 = 1'b1; cfg_init_preset = 1'b1;
    ct[0] = 1'b1; #2;
    chk(mc_fb, 1'b0, "R5 unselected term ignored");
    ct[0] = 1'b0;
    ct[1] = 1'b1; #2;
    chk(mc_fb, 1'b1, "R5 preset from term 1");
    ct[1] = 1'b0;
    cfg_init_en = 1'b0; cfg_init_preset = 1'b0;
    ct[1:0] = 2'b11; #2;
    chk(mc_fb, 1'b1, "R5 disabled initialisation ignored");
    ct[1:0] = 2'b00;
    cfg_init_en = 1'b1;
    ct[1] = 1'b1; #2;
    sum = 1'b1;
    pulse_line(1'b0, 1);
    chk(mc_fb, 1'b0, "R5 clear overrides clock edge");
    ct[1] = 1'b0; #2;
    pulse_line(1'b0, 1);
    chk(mc_fb, 1'b1, "R1 load after clear released");

    // R6: reset wins over preset
    cfg_init_preset = 1'b1;
    ct[1] = 1'b1; #2;
    rst_n = 1'b0; #2;
    chk(mc_fb, 1'b0, "R6 reset over preset");
    ct[1] = 1'b0; #2;
    rst_n = 1'b1; #2;
    chk(mc_fb, 1'b0, "R6 bit zero after reset");

    // R10 R9: bypass and feedback split
    cfg_bypass = 1'b1; cfg_oe_sel = 3'd4;
    sum = 1'b1; #2;
    chk(mc_fb, 1'b1, "R10 bypass high");
    chk(pad_fb, 1'b1, "R9 driven pad feedback");
    sum = 1'b0; #2;
    chk(mc_fb, 1'b0, "R10 bypass low");
    chk(pad_o, 1'b0, "R9 pad value in bypass");
    cfg_bypass = 1'b0;
    ct[1] = 1'b1; #2; ct[1] = 1'b0; #2;
    cfg_oe_sel = 3'd5; pad_in = 1'b0; #2;
    chk(mc_fb, 1'b1, "R9 cell feedback while disabled");
    chk(pad_fb, 1'b0, "R9 pad feedback low input");
    pad_in = 1'b1; #2;
    chk(pad_fb, 1'b1, "R9 pad feedback high input");
    cfg_bypass = 1'b1; #2;
    chk(mc_fb, 1'b0, "R10 bypass hides stored bit");
    cfg_bypass = 1'b0; #2;
    chk(mc_fb, 1'b1, "R10 stored bit kept");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule